// File: doc/BRIEF.md
# Transmit FIFO Start Threshold Gate

This block decides when an output port may begin to send the frame at the head of its transmit FIFO. It watches how many bytes the FIFO holds, whether the end of the head frame has already been written, whether a head frame exists at all, and whether the port runs at 100 Mb/s. A programmed threshold, counted in 8-byte units, makes a fast port store data before it starts. A threshold of zero, or a port that is not at 100 Mb/s, lets the frame start as soon as it is present (cut-through). If the whole frame is already in the FIFO, the threshold does not apply.

The threshold arrives as an 8-bit field inside a 32-bit timing control word, written with a one-cycle strobe. The start decision is latched. Once `start_ok` is high it stays high until the transmitter pulses `frame_done`, however the FIFO level moves in the meantime.

A three-state machine drives the decision:
- `GS_IDLE`: no frame is pending.
- `GS_HOLD`: a frame is present but may not start yet.
- `GS_GRANT`: `start_ok` is asserted.

The transitions are:
- idle-to-grant: a head frame is present and ready.
- idle-to-hold: a head frame is present but not ready.
- hold-to-grant: the frame becomes ready.
- hold-to-idle: the head frame is withdrawn.
- grant-to-idle: `frame_done` is pulsed.

Every other case keeps the current state.

Top module: `tx_start_gate`

## Requirements
- R1: After reset, `start_ok` is 0 and the stored threshold is 0. A fast port with a head frame and an empty FIFO is then granted, as in cut-through.
- R2: When `cfg_we` is high at a clock edge, bits 21:14 of `cfg_word` are stored as the threshold. All other bits of `cfg_word` are ignored. The new value governs decisions from the next cycle.
- R3: On a 100 Mb/s port (`port_fast`=1) with a non-zero threshold T and no end-of-frame in the FIFO, start is allowed when `fifo_level` >= 8*T, and not when `fifo_level` = 8*T-1.
- R4: A threshold of 0 allows start whenever `head_valid` is 1, whatever `fifo_level` is.
- R5: When `eof_in_fifo`=1, start is allowed whatever the threshold and level are.
- R6: When `port_fast`=0, the threshold is ignored and start is allowed whenever `head_valid` is 1.
- R7: `start_ok` rises on the first clock edge at which the start condition holds. It is therefore visible one cycle after the inputs that satisfy it.
- R8: Once `start_ok` is 1, it stays 1 until `frame_done` is sampled high. This holds even if the level falls, `eof_in_fifo` drops, or the threshold is rewritten.
- R9: `frame_done` sampled while `start_ok`=1 clears `start_ok` at that edge. `frame_done` while not granted has no effect.
- R10: With `head_valid`=0, `start_ok` never rises. A frame withdrawn while waiting returns the gate to idle.
- R11: The compare spans 11 bits, so T=255 requires 2040 bytes without wrap: 2039 is refused and 2040 is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the timing control word |
| cfg_word | input | 32 | Timing control word; threshold in bits 21:14 |
| port_fast | input | 1 | 1 when the port runs at 100 Mb/s |
| fifo_level | input | 11 | Bytes currently held in the transmit FIFO |
| eof_in_fifo | input | 1 | End of the head frame is already in the FIFO |
| head_valid | input | 1 | A head frame is present in the FIFO |
| frame_done | input | 1 | Pulse: the granted frame has been sent |
| start_ok | output | 1 | Permission to start sending the head frame |

## Verification
Each start decision is due exactly one clock edge after the inputs that satisfy it. A release by `frame_done` is likewise visible one edge later. A threshold write takes one edge to store and then governs the decision on the following edge. The bench therefore changes inputs on the falling edge and samples `start_ok` on the next falling edge. That sample lies after exactly one rising edge, and a sample taken before that edge confirms the output has not moved early. Hold behaviour is checked over several consecutive falling edges while the inputs that first granted the frame are taken away.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_HOLD  = 2'd1,
        GS_GRANT = 2'd2
    } gate_state_t;

endpackage

// File: rtl/tsg_thr_reg.sv
module tsg_thr_reg #(
    parameter int WORD_W  = 32,
    parameter int THR_W   = 8,
    parameter int THR_LSB = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] word,
    output logic [THR_W-1:0]  thr
);

    localparam int THR_MSB = THR_LSB + THR_W - 1;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{word[WORD_W-1:THR_MSB+1], word[THR_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0;
        end else if (we) begin
            thr <= word[THR_MSB:THR_LSB];
        end
    end

    // R2: the written field lands in the register one edge later
    assert_field_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (thr == $past(word[THR_MSB:THR_LSB])));

    // R2: without a write the threshold keeps its value
    assert_field_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(thr));

endmodule

// File: rtl/tsg_ready.sv
module tsg_ready #(
    parameter int OCC_W      = 11,
    parameter int THR_W      = 8,
    parameter int UNIT_SHIFT = 3
) (
    input  logic [THR_W-1:0] thr,
    input  logic             fast,
    input  logic [OCC_W-1:0] level,
    input  logic             eof,
    input  logic             head,
    output logic             ready
);

    localparam int NEED_W = THR_W + UNIT_SHIFT;
    localparam int CMP_W  = (OCC_W > NEED_W) ? OCC_W : NEED_W;

    logic [CMP_W-1:0] need_bytes;
    logic [CMP_W-1:0] have_bytes;
    logic             cut_through;
    logic             filled;

    generate
        if (OCC_W >= NEED_W) begin : g_level_wide
            assign have_bytes = level;
            assign need_bytes = CMP_W'({thr, {UNIT_SHIFT{1'b0}}});
        end else begin : g_level_narrow
            assign have_bytes = CMP_W'(level);
            assign need_bytes = {thr, {UNIT_SHIFT{1'b0}}};
        end
    endgenerate

    always_comb begin
        cut_through = (thr == '0) || !fast;
        filled      = (have_bytes >= need_bytes);
        ready       = head && (cut_through || eof || filled);
    end

    // R5: a complete frame in the FIFO is always ready
    always_comb begin
        if (head && eof) begin
            assert_eof_override_R5: assert (ready);
        end
    end

endmodule

// File: rtl/tsg_fsm.sv
module tsg_fsm
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head,
    input  logic ready,
    input  logic done,
    output logic start_ok
);

    gate_state_t state_q;
    gate_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (head && ready) begin
                    state_d = GS_GRANT;
                end else if (head) begin
                    state_d = GS_HOLD;
                end
            end
            GS_HOLD: begin
                if (!head) begin
                    state_d = GS_IDLE;
                end else if (ready) begin
                    state_d = GS_GRANT;
                end
            end
            GS_GRANT: begin
                if (done) begin
                    state_d = GS_IDLE;
                end
            end
            default: state_d = GS_IDLE;
        endcase
    end

    always_comb begin
        start_ok = (state_q == GS_GRANT);
    end

    // R8: a grant is held until the frame is reported sent
    assert_hold_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && !done) |=> start_ok);

    // R9: the sent strobe releases the grant
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && done) |=> !start_ok);

    // R7: a grant only appears after a ready cycle
    assert_rise_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_ok) |-> $past(ready));

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
    parameter int WORD_W     = 32,
    parameter int THR_W      = 8,
    parameter int THR_LSB    = 14,
    parameter int OCC_W      = 11,
    parameter int UNIT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              port_fast,
    input  logic [OCC_W-1:0]  fifo_level,
    input  logic              eof_in_fifo,
    input  logic              head_valid,
    input  logic              frame_done,
    output logic              start_ok
);

    localparam int NEED_W = THR_W + UNIT_SHIFT;
    localparam int CMP_W  = (OCC_W > NEED_W) ? OCC_W : NEED_W;

    logic [THR_W-1:0] thr;
    logic             ready;

    tsg_thr_reg #(
        .WORD_W  (WORD_W),
        .THR_W   (THR_W),
        .THR_LSB (THR_LSB)
    ) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .word  (cfg_word),
        .thr   (thr)
    );

    tsg_ready #(
        .OCC_W      (OCC_W),
        .THR_W      (THR_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_ready (
        .thr   (thr),
        .fast  (port_fast),
        .level (fifo_level),
        .eof   (eof_in_fifo),
        .head  (head_valid),
        .ready (ready)
    );

    tsg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .head     (head_valid),
        .ready    (ready),
        .done     (frame_done),
        .start_ok (start_ok)
    );

    logic [CMP_W-1:0] chk_need;
    logic [CMP_W-1:0] chk_have;
    assign chk_need = CMP_W'(thr) * CMP_W'(2 ** UNIT_SHIFT);
    assign chk_have = CMP_W'(fifo_level);

    // R3: a gated fast port never starts below the byte threshold
    assert_threshold_met_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_ok) && $past(port_fast && !eof_in_fifo && (thr != '0)))
        |-> $past(chk_have >= chk_need));

    // R10: no grant appears without a head frame
    assert_needs_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_ok) |-> $past(head_valid));

endmodule

// File: tb/sim_tx_start_gate.sv
module sim_tx_start_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        port_fast = 1'b1;
    logic [10:0] fifo_level = '0;
    logic        eof_in_fifo = 1'b0;
    logic        head_valid = 1'b0;
    logic        frame_done = 1'b0;
    logic        start_ok;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tx_start_gate u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_word    (cfg_word),
        .port_fast   (port_fast),
        .fifo_level  (fifo_level),
        .eof_in_fifo (eof_in_fifo),
        .head_valid  (head_valid),
        .frame_done  (frame_done),
        .start_ok    (start_ok)
    );

    // vector: {thr[7:0], fast, level[10:0], eof, expected start}
    localparam int NV = 15;
    localparam logic [21:0] VEC [NV] = '{
        {8'd0,   1'b1, 11'd0,    1'b0, 1'b1},  // R4
        {8'd0,   1'b1, 11'd1,    1'b0, 1'b1},  // R4
        {8'd4,   1'b1, 11'd31,   1'b0, 1'b0},  // R3
        {8'd4,   1'b1, 11'd32,   1'b0, 1'b1},  // R3
        {8'd4,   1'b1, 11'd33,   1'b0, 1'b1},  // R3
        {8'd4,   1'b1, 11'd0,    1'b1, 1'b1},  // R5
        {8'd200, 1'b1, 11'd100,  1'b1, 1'b1},  // R5
        {8'd4,   1'b0, 11'd0,    1'b0, 1'b1},  // R6
        {8'd200, 1'b0, 11'd5,    1'b0, 1'b1},  // R6
        {8'd1,   1'b1, 11'd7,    1'b0, 1'b0},  // R3
        {8'd1,   1'b1, 11'd8,    1'b0, 1'b1},  // R3
        {8'd255, 1'b1, 11'd2039, 1'b0, 1'b0},  // R11
        {8'd255, 1'b1, 11'd2040, 1'b0, 1'b1},  // R11
        {8'd255, 1'b1, 11'd2047, 1'b0, 1'b1},  // R11
        {8'd128, 1'b1, 11'd1023, 1'b0, 1'b0}   // R3
    };

    task automatic check(input logic exp, input string tag);
        n_checks++;
        if (start_ok !== exp) begin
            n_fail++;
            $display("FAIL %s: start_ok=%0b expected=%0b", tag, start_ok, exp);
        end
    endtask

    // threshold goes in bits 21:14; other bits set to show they are ignored (R2)
    task automatic write_thr(input logic [7:0] t);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_word = 32'hFFC0_3FFF | (32'(t) << 14);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic clear_frame();
        head_valid = 1'b0;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        eof_in_fifo = 1'b0;
        fifo_level = '0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(1'b0, "R1 start_ok low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 start_ok low after reset");
        head_valid = 1'b1;
        @(negedge clk);
        check(1'b1, "R1 default threshold is cut-through");
        clear_frame();
        check(1'b0, "R9 released after frame_done");

        for (int i = 0; i < NV; i++) begin
            write_thr(VEC[i][21:14]);
            port_fast   = VEC[i][13];
            fifo_level  = VEC[i][12:2];
            eof_in_fifo = VEC[i][1];
            head_valid  = 1'b1;
            @(negedge clk);
            check(VEC[i][0], $sformatf("R2/R3-R6/R11 vector %0d", i));
            clear_frame();
        end

        // R7: one-edge latency
        port_fast = 1'b1;
        write_thr(8'd4);
        fifo_level = 11'd31;
        head_valid = 1'b1;
        @(negedge clk);
        check(1'b0, "R7 below threshold");
        fifo_level = 11'd32;
        #1;
        check(1'b0, "R7 not before the edge");
        @(negedge clk);
        check(1'b1, "R7 granted one edge later");

        // R8: hold despite inputs falling away and a rewrite
        fifo_level = '0;
        cfg_we = 1'b1;
        cfg_word = 32'(8'd255) << 14;
        @(negedge clk);
        cfg_we = 1'b0;
        check(1'b1, "R8 held after level drop");
        repeat (3) @(negedge clk);
        check(1'b1, "R8 held over several cycles");

        // R9: release, then re-evaluate under threshold 255
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(1'b0, "R9 released by frame_done");
        @(negedge clk);
        check(1'b0, "R9 new frame held by threshold");
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(1'b0, "R9 frame_done while waiting ignored");
        fifo_level = 11'd2040;
        @(negedge clk);
        check(1'b1, "R9 wait state intact, granted on fill");
        clear_frame();

        // R2: field zero with all other bits set gives cut-through
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_word = 32'hFFC0_3FFF;
        @(negedge clk);
        cfg_we = 1'b0;
        head_valid = 1'b1;
        @(negedge clk);
        check(1'b1, "R2 other bits ignored");
        clear_frame();

        // R10: no head, no start; withdrawal while waiting
        head_valid = 1'b0;
        fifo_level = 11'd100;
        @(negedge clk);
        check(1'b0, "R10 no head frame");
        write_thr(8'd4);
        fifo_level = '0;
        head_valid = 1'b1;
        @(negedge clk);
        head_valid = 1'b0;
        @(negedge clk);
        fifo_level = 11'd40;
        @(negedge clk);
        check(1'b0, "R10 withdrawn frame not granted");
        head_valid = 1'b1;
        @(negedge clk);
        check(1'b1, "R10 new head granted");
        clear_frame();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule